// File: doc/BRIEF.md
# Physical memory space decoder

The decoder looks at every CPU memory cycle and decides which physical device space serves it. Its input is a 26-bit physical address with a valid strobe. There are six possible targets: system DRAM, three ROM/Flash chip-select spaces, an external card socket that can take over two of the ROM selects, and the external ISA/VL-bus space. The decoder asserts exactly one of these selects and presents the device address. For a direct decode the device address is the CPU address itself. For a hit in an indirect mapping window it is the translated address.

A small write-only register file sets the decode rules:
- the size of the DRAM direct range;
- the placement of the ROM0 direct boot region;
- an ISA overlap window, which only acts below 16 MB and steals cycles from DRAM or ROM0;
- a set of indirect mapping windows, each with a base, a size, a target page and a destination space.

Any address that nothing claims goes to the ISA space, with all 26 address bits passed through. Two straps are captured while reset is held. One gives the ROM0 data width. The other redirects the ROM1 and ROM2 selects to the card socket; a software bit can also force this redirect.

Addresses are split into 16 KB pages. The page number is bits [25:14] and the in-page offset is bits [13:0]. Configuration writes take effect on the clock edge where `cfgWe` is high. The decode path from `cpuAddr` to the outputs is purely combinational.

Top module: `mem_space_dec`

## Requirements
- R1: While `addrValid` is high, exactly one bit of `spaceSel` is set. While it is low, `spaceSel` is all zero. The bit encoding is: bit0 DRAM, bit1 ROM0, bit2 ROM1, bit3 ROM2, bit4 card socket, bit5 ISA.
- R2: After reset, only two decodes are active: the ROM0 boot region, pages 0x3FC to 0x3FF (addresses 0x0FF0000 to 0x0FFFFFF), and the ISA default. The DRAM size is 0, the overlap window is off, and every indirect window is off.
- R3: An address claimed by no other space selects ISA. `devAddr` then equals the full 26-bit `cpuAddr`, including addresses above 16 MB.
- R4: Register 0 bits [6:0] give the DRAM size in MB. An address below size×1 MB selects DRAM, with `devAddr` equal to `cpuAddr`. The address at exactly size×1 MB does not select DRAM.
- R5: Register 1 places the ROM0 direct region: bits [11:0] are the base page and bits [23:12] are the size in pages. Within the region ROM0 is selected with `devAddr` equal to `cpuAddr`, but only when DRAM does not claim the address.
- R6: Register 2 sets the ISA overlap window: bits [11:0] are the base page, bits [23:12] the size in pages, and bit 24 the enable. A hit forces ISA even inside DRAM. The window never acts on addresses at or above 16 MB.
- R7: Indirect window w is set by two registers. Register 4+2w holds the base page [11:0], the size in pages [23:12], the space [25:24] and the enable [31]. The space codes are 0 DRAM, 1 ROM0, 2 ROM1 and 3 ROM2. Register 5+2w holds the target page [11:0]. A hit has priority over the overlap window, DRAM and ROM0. The translated address is `devAddr` = {target + (page − base), offset[13:0]}.
- R8: When several enabled windows hit the same address, the window with the lowest index wins.
- R9: If `remapStrap` was high during reset, or register 0 bit 8 is set, a window hit to ROM1 or ROM2 selects the card socket (bit4) instead. The translated address is unchanged, and ROM0 and direct decodes are not affected.
- R10: `rom0Width` holds the value of `romWidthStrap` captured during reset (00 = 8 bit, 01 = 16 bit, 10 = 32 bit). Changes to the strap after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; the straps are captured while it is high |
| romWidthStrap | input | 2 | ROM0 data width strap |
| remapStrap | input | 1 | Strap that redirects ROM1/ROM2 to the card socket |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 4 | Configuration register index |
| cfgWdata | input | 32 | Configuration write data |
| addrValid | input | 1 | A memory cycle is active |
| cpuAddr | input | 26 | CPU physical address |
| spaceSel | output | 6 | One-hot space select |
| devAddr | output | 26 | Device address (direct or translated) |
| rom0Width | output | 2 | Captured ROM0 data width |

## Verification
The hardest case to reach is an address claimed by several rules at once, for example a window that lies inside the overlap window that lies inside DRAM. Each priority level only shows when every higher level misses. The stimulus therefore builds the configuration in layers: DRAM first, then a ROM0 region under it, then an overlap window, then stacked windows. After each layer it probes addresses on both sides of every boundary. The strap-driven redirect needs a second reset with the strap high, so the bench repeats the reset and rebuilds a window.

// File: rtl/mem_space_pkg.sv
package mem_space_pkg;
  localparam int SPACE_N   = 6;
  localparam int WIN_IDX_W = 4;

  localparam int SP_DRAM = 0;
  localparam int SP_ROM0 = 1;
  localparam int SP_ROM1 = 2;
  localparam int SP_ROM2 = 3;
  localparam int SP_CARD = 4;
  localparam int SP_ISA  = 5;

  typedef enum logic [1:0] {
    WS_DRAM = 2'd0,
    WS_ROM0 = 2'd1,
    WS_ROM1 = 2'd2,
    WS_ROM2 = 2'd3
  } win_space_e;

  typedef struct packed {
    logic [SPACE_N-1:0]   sel;
    logic                 xlate;
    logic [WIN_IDX_W-1:0] win;
  } dec_strobe_t;
endpackage

// File: rtl/mem_space_cfg.sv
module mem_space_cfg
  import mem_space_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int PAGE_SH    = 14,
  parameter int DRAM_SH    = 20,
  parameter int NUM_WIN    = 4,
  parameter int CFG_DW     = 32,
  parameter int CFG_AW     = 4,
  parameter int BOOT_BASE  = 12'h3FC,
  parameter int BOOT_PAGES = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [1:0]                       romWidthStrap,
  input  logic                             remapStrap,
  input  logic                             cfgWe,
  input  logic [CFG_AW-1:0]                cfgAddr,
  input  logic [CFG_DW-1:0]                cfgWdata,
  output logic [ADDR_W-DRAM_SH:0]          dramSize,
  output logic [ADDR_W-PAGE_SH-1:0]        rom0Base,
  output logic [ADDR_W-PAGE_SH-1:0]        rom0Size,
  output logic                             ovlEn,
  output logic [ADDR_W-PAGE_SH-1:0]        ovlBase,
  output logic [ADDR_W-PAGE_SH-1:0]        ovlSize,
  output logic [NUM_WIN-1:0]               winEn,
  output logic [NUM_WIN-1:0][ADDR_W-PAGE_SH-1:0] winBase,
  output logic [NUM_WIN-1:0][ADDR_W-PAGE_SH-1:0] winSize,
  output logic [NUM_WIN-1:0][1:0]          winSpace,
  output logic [NUM_WIN-1:0][ADDR_W-PAGE_SH-1:0] winTarget,
  output logic                             remapOn,
  output logic [1:0]                       rom0Width
);
  localparam int PAGE_W    = ADDR_W - PAGE_SH;
  localparam int DSZ_W     = ADDR_W - DRAM_SH + 1;
  localparam int REMAP_BIT = DSZ_W + 1;
  localparam logic [CFG_AW-1:0] A_CTRL = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] A_ROM0 = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] A_OVL  = CFG_AW'(2);

  logic swRemap;
  logic strapRemap;

  always_ff @(posedge clk) begin
    if (rst) begin
      dramSize   <= '0;
      swRemap    <= 1'b0;
      rom0Base   <= PAGE_W'(BOOT_BASE);
      rom0Size   <= PAGE_W'(BOOT_PAGES);
      ovlEn      <= 1'b0;
      ovlBase    <= '0;
      ovlSize    <= '0;
      strapRemap <= remapStrap;
      rom0Width  <= romWidthStrap;
    end else if (cfgWe) begin
      case (cfgAddr)
        A_CTRL: begin
          dramSize <= cfgWdata[DSZ_W-1:0];
          swRemap  <= cfgWdata[REMAP_BIT];
        end
        A_ROM0: begin
          rom0Base <= cfgWdata[PAGE_W-1:0];
          rom0Size <= cfgWdata[2*PAGE_W-1:PAGE_W];
        end
        A_OVL: begin
          ovlBase <= cfgWdata[PAGE_W-1:0];
          ovlSize <= cfgWdata[2*PAGE_W-1:PAGE_W];
          ovlEn   <= cfgWdata[2*PAGE_W];
        end
        default: ;
      endcase
    end
  end

  assign remapOn = strapRemap | swRemap;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_winReg
    localparam logic [CFG_AW-1:0] A_SHAPE  = CFG_AW'(4 + 2*w);
    localparam logic [CFG_AW-1:0] A_TARGET = CFG_AW'(5 + 2*w);
    always_ff @(posedge clk) begin
      if (rst) begin
        winEn[w]     <= 1'b0;
        winBase[w]   <= '0;
        winSize[w]   <= '0;
        winSpace[w]  <= '0;
        winTarget[w] <= '0;
      end else if (cfgWe && cfgAddr == A_SHAPE) begin
        winBase[w]  <= cfgWdata[PAGE_W-1:0];
        winSize[w]  <= cfgWdata[2*PAGE_W-1:PAGE_W];
        winSpace[w] <= cfgWdata[2*PAGE_W+1:2*PAGE_W];
        winEn[w]    <= cfgWdata[CFG_DW-1];
      end else if (cfgWe && cfgAddr == A_TARGET) begin
        winTarget[w] <= cfgWdata[PAGE_W-1:0];
      end
    end
  end

  AST_WIDTH_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
    $stable(rom0Width)); // R10
endmodule

// File: rtl/mem_space_dp.sv
module mem_space_dp
  import mem_space_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int PAGE_SH = 14,
  parameter int DRAM_SH = 20,
  parameter int LOW_SH  = 24,
  parameter int NUM_WIN = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [ADDR_W-1:0]                cpuAddr,
  input  logic [ADDR_W-DRAM_SH:0]          dramSize,
  input  logic [ADDR_W-PAGE_SH-1:0]        rom0Base,
  input  logic [ADDR_W-PAGE_SH-1:0]        rom0Size,
  input  logic                             ovlEn,
  input  logic [ADDR_W-PAGE_SH-1:0]        ovlBase,
  input  logic [ADDR_W-PAGE_SH-1:0]        ovlSize,
  input  logic [NUM_WIN-1:0]               winEn,
  input  logic [NUM_WIN-1:0][ADDR_W-PAGE_SH-1:0] winBase,
  input  logic [NUM_WIN-1:0][ADDR_W-PAGE_SH-1:0] winSize,
  input  logic [NUM_WIN-1:0][ADDR_W-PAGE_SH-1:0] winTarget,
  input  dec_strobe_t                      strobe,
  output logic [NUM_WIN-1:0]               winHit,
  output logic                             ovlHit,
  output logic                             dramHit,
  output logic                             rom0Hit,
  output logic [ADDR_W-1:0]                devAddr
);
  localparam int PAGE_W    = ADDR_W - PAGE_SH;
  localparam int DSZ_W     = ADDR_W - DRAM_SH + 1;
  localparam int WIN_SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [PAGE_W-1:0] curPage;
  logic [ADDR_W-1:0] xlAddr [NUM_WIN];

  assign curPage = cpuAddr[ADDR_W-1:PAGE_SH];

  function automatic logic inRange(input logic [PAGE_W-1:0] pg,
                                   input logic [PAGE_W-1:0] base,
                                   input logic [PAGE_W-1:0] size);
    logic [PAGE_W:0] limit;
    limit = {1'b0, base} + {1'b0, size};
    return ({1'b0, pg} >= {1'b0, base}) && ({1'b0, pg} < limit);
  endfunction

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [PAGE_W-1:0] relPage;
    assign relPage   = curPage - winBase[w];
    assign winHit[w] = winEn[w] && inRange(curPage, winBase[w], winSize[w]);
    assign xlAddr[w] = {winTarget[w] + relPage, cpuAddr[PAGE_SH-1:0]};
  end

  assign ovlHit  = ovlEn && (cpuAddr[ADDR_W-1:LOW_SH] == '0)
                   && inRange(curPage, ovlBase, ovlSize);
  assign dramHit = {1'b0, cpuAddr[ADDR_W-1:DRAM_SH]} < dramSize[DSZ_W-1:0];
  assign rom0Hit = inRange(curPage, rom0Base, rom0Size);

  assign devAddr = strobe.xlate ? xlAddr[strobe.win[WIN_SEL_W-1:0]] : cpuAddr;

  AST_OVL_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    ovlHit |-> (cpuAddr < (ADDR_W'(1) << LOW_SH))); // R6
  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
    !strobe.xlate |-> devAddr == cpuAddr); // R3
endmodule

// File: rtl/mem_space_ctrl.sv
module mem_space_ctrl
  import mem_space_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    addrValid,
  input  logic [NUM_WIN-1:0]      winHit,
  input  logic [NUM_WIN-1:0][1:0] winSpace,
  input  logic                    ovlHit,
  input  logic                    dramHit,
  input  logic                    rom0Hit,
  input  logic                    remapOn,
  output dec_strobe_t             strobe
);
  localparam int WIN_SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic                 anyWin;
  logic [WIN_IDX_W-1:0] firstWin;
  win_space_e           firstSpace;

  always_comb begin
    anyWin   = 1'b0;
    firstWin = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (winHit[i]) begin
        anyWin   = 1'b1;
        firstWin = WIN_IDX_W'(i);
      end
    end
    firstSpace = win_space_e'(winSpace[firstWin[WIN_SEL_W-1:0]]);
  end

  always_comb begin
    strobe = '0;
    if (addrValid) begin
      if (anyWin) begin
        strobe.xlate = 1'b1;
        strobe.win   = firstWin;
        case (firstSpace)
          WS_DRAM: strobe.sel[SP_DRAM] = 1'b1;
          WS_ROM0: strobe.sel[SP_ROM0] = 1'b1;
          WS_ROM1: strobe.sel[remapOn ? SP_CARD : SP_ROM1] = 1'b1;
          default: strobe.sel[remapOn ? SP_CARD : SP_ROM2] = 1'b1;
        endcase
      end else if (ovlHit) begin
        strobe.sel[SP_ISA] = 1'b1;
      end else if (dramHit) begin
        strobe.sel[SP_DRAM] = 1'b1;
      end else if (rom0Hit) begin
        strobe.sel[SP_ROM0] = 1'b1;
      end else begin
        strobe.sel[SP_ISA] = 1'b1;
      end
    end
  end

  AST_SEL_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    addrValid |-> $countones(strobe.sel) == 1); // R1
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !addrValid |-> strobe.sel == '0); // R1
  AST_REMAP_HIDES_ROM12: assert property (@(posedge clk) disable iff (rst)
    remapOn |-> !strobe.sel[SP_ROM1] && !strobe.sel[SP_ROM2]); // R9
  AST_WIN_WINS: assert property (@(posedge clk) disable iff (rst)
    (addrValid && winHit != '0) |-> strobe.xlate && !strobe.sel[SP_ISA]); // R7
endmodule

// File: rtl/mem_space_dec.sv
module mem_space_dec
  import mem_space_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int PAGE_SH    = 14,
  parameter int DRAM_SH    = 20,
  parameter int LOW_SH     = 24,
  parameter int NUM_WIN    = 4,
  parameter int CFG_DW     = 32,
  parameter int BOOT_BASE  = 12'h3FC,
  parameter int BOOT_PAGES = 4,
  localparam int CFG_AW    = $clog2(4 + 2*NUM_WIN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          romWidthStrap,
  input  logic                remapStrap,
  input  logic                cfgWe,
  input  logic [CFG_AW-1:0]   cfgAddr,
  input  logic [CFG_DW-1:0]   cfgWdata,
  input  logic                addrValid,
  input  logic [ADDR_W-1:0]   cpuAddr,
  output logic [SPACE_N-1:0]  spaceSel,
  output logic [ADDR_W-1:0]   devAddr,
  output logic [1:0]          rom0Width
);
  localparam int PAGE_W = ADDR_W - PAGE_SH;
  localparam int DSZ_W  = ADDR_W - DRAM_SH + 1;

  logic [DSZ_W-1:0]  dramSize;
  logic [PAGE_W-1:0] rom0Base, rom0Size, ovlBase, ovlSize;
  logic              ovlEn, remapOn;
  logic [NUM_WIN-1:0]             winEn, winHit;
  logic [NUM_WIN-1:0][PAGE_W-1:0] winBase, winSize, winTarget;
  logic [NUM_WIN-1:0][1:0]        winSpace;
  logic              ovlHit, dramHit, rom0Hit;
  dec_strobe_t       strobe;

  mem_space_cfg #(
    .ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH), .DRAM_SH(DRAM_SH), .NUM_WIN(NUM_WIN),
    .CFG_DW(CFG_DW), .CFG_AW(CFG_AW), .BOOT_BASE(BOOT_BASE), .BOOT_PAGES(BOOT_PAGES)
  ) cfg_i (
    .clk(clk), .rst(rst), .romWidthStrap(romWidthStrap), .remapStrap(remapStrap),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .dramSize(dramSize), .rom0Base(rom0Base), .rom0Size(rom0Size),
    .ovlEn(ovlEn), .ovlBase(ovlBase), .ovlSize(ovlSize),
    .winEn(winEn), .winBase(winBase), .winSize(winSize), .winSpace(winSpace),
    .winTarget(winTarget), .remapOn(remapOn), .rom0Width(rom0Width)
  );

  mem_space_dp #(
    .ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH), .DRAM_SH(DRAM_SH), .LOW_SH(LOW_SH),
    .NUM_WIN(NUM_WIN)
  ) dp_i (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .dramSize(dramSize),
    .rom0Base(rom0Base), .rom0Size(rom0Size),
    .ovlEn(ovlEn), .ovlBase(ovlBase), .ovlSize(ovlSize),
    .winEn(winEn), .winBase(winBase), .winSize(winSize), .winTarget(winTarget),
    .strobe(strobe), .winHit(winHit), .ovlHit(ovlHit), .dramHit(dramHit),
    .rom0Hit(rom0Hit), .devAddr(devAddr)
  );

  mem_space_ctrl #(.NUM_WIN(NUM_WIN)) ctrl_i (
    .clk(clk), .rst(rst), .addrValid(addrValid), .winHit(winHit),
    .winSpace(winSpace), .ovlHit(ovlHit), .dramHit(dramHit), .rom0Hit(rom0Hit),
    .remapOn(remapOn), .strobe(strobe)
  );

  assign spaceSel = strobe.sel;
endmodule

// File: tb/mem_space_dec_tb_top.sv
module mem_space_dec_tb_top;
  localparam logic [5:0] S_DRAM = 6'b000001;
  localparam logic [5:0] S_ROM0 = 6'b000010;
  localparam logic [5:0] S_ROM1 = 6'b000100;
  localparam logic [5:0] S_ROM2 = 6'b001000;
  localparam logic [5:0] S_CARD = 6'b010000;
  localparam logic [5:0] S_ISA  = 6'b100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  romWidthStrap = 2'b01;
  logic        remapStrap = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        addrValid = 1'b0;
  logic [25:0] cpuAddr = '0;
  logic [5:0]  spaceSel;
  logic [25:0] devAddr;
  logic [1:0]  rom0Width;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0]  sel;
    logic [25:0] addr;
    bit          chkAddr;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  mem_space_dec dut_i (
    .clk(clk), .rst(rst), .romWidthStrap(romWidthStrap), .remapStrap(remapStrap),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .addrValid(addrValid), .cpuAddr(cpuAddr),
    .spaceSel(spaceSel), .devAddr(devAddr), .rom0Width(rom0Width)
  );

  task automatic doReset(input logic [1:0] ws, input logic rs);
    @(negedge clk);
    rst = 1'b1; romWidthStrap = ws; remapStrap = rs; addrValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'(idx); cfgWdata = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic drive(input logic v, input logic [25:0] a, input logic [5:0] s,
                       input logic [25:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    addrValid = v; cpuAddr = a;
    e.sel = s; e.addr = d; e.chkAddr = v; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkWidth(input logic [1:0] exp, input string tag);
    #5;
    total++;
    if (rom0Width !== exp) begin
      bad++;
      $display("FAIL %s rom0Width act=%b exp=%b", tag, rom0Width, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (expQ.size() != 0) begin
        e = expQ.pop_front();
        total++;
        if (spaceSel !== e.sel) begin
          bad++;
          $display("FAIL %s spaceSel act=%b exp=%b", e.tag, spaceSel, e.sel);
        end
        if (e.chkAddr) begin
          total++;
          if (devAddr !== e.addr) begin
            bad++;
            $display("FAIL %s devAddr act=%h exp=%h", e.tag, devAddr, e.addr);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    doReset(2'b01, 1'b0);
    checkWidth(2'b01, "R10 strap capture");
    // R2 / R3 reset state
    drive(1, 26'h0FF0010, S_ROM0, 26'h0FF0010, "R2 boot region");
    drive(1, 26'h0FFFFFF, S_ROM0, 26'h0FFFFFF, "R2 boot top");
    drive(1, 26'h0FEFFFF, S_ISA,  26'h0FEFFFF, "R2 below boot");
    drive(1, 26'h0000100, S_ISA,  26'h0000100, "R2 no dram");
    drive(1, 26'h3ABCDEF, S_ISA,  26'h3ABCDEF, "R3 high isa");
    drive(0, 26'h0FF0010, 6'b0,   26'h0, "R1 idle");
    drain();
    // R4 DRAM 8 MB
    wr(0, 32'd8);
    drive(1, 26'h07FFFFF, S_DRAM, 26'h07FFFFF, "R4 dram top");
    drive(1, 26'h0800000, S_ISA,  26'h0800000, "R4 dram end");
    drive(0, 26'h0000000, 6'b0,   26'h0, "R1 idle dram");
    drain();
    // R5 ROM0 region
    wr(1, 32'h0000_2100);
    drive(1, 26'h0400000, S_DRAM, 26'h0400000, "R5 dram over rom0");
    drain();
    wr(1, 32'h0000_2800);
    drive(1, 26'h2000000, S_ROM0, 26'h2000000, "R5 rom0 base");
    drive(1, 26'h2007FFF, S_ROM0, 26'h2007FFF, "R5 rom0 last");
    drive(1, 26'h2008000, S_ISA,  26'h2008000, "R5 rom0 end");
    drive(1, 26'h0FF0010, S_ISA,  26'h0FF0010, "R5 old boot moved");
    drain();
    // R6 overlap window
    wr(2, 32'h0100_4040);
    drive(1, 26'h0100000, S_ISA,  26'h0100000, "R6 overlap hit");
    drive(1, 26'h010FFFF, S_ISA,  26'h010FFFF, "R6 overlap last");
    drive(1, 26'h00FFFFF, S_DRAM, 26'h00FFFFF, "R6 below overlap");
    drive(1, 26'h0110000, S_DRAM, 26'h0110000, "R6 above overlap");
    drain();
    wr(0, 32'd64);
    wr(2, 32'h0100_4900);
    drive(1, 26'h2400000, S_DRAM, 26'h2400000, "R6 high overlap ignored");
    drain();
    wr(0, 32'd8);
    wr(2, 32'h0100_4040);
    // R7 / R8 windows
    wr(4, 32'h8200_2080);
    wr(5, 32'h0000_0010);
    wr(6, 32'h8300_1080);
    wr(7, 32'h0000_0300);
    wr(8, 32'h8000_1041);
    wr(9, 32'h0000_07FF);
    drive(1, 26'h0204567, S_ROM1, 26'h0044567, "R7 window rom1");
    drive(1, 26'h01FFFFF, S_DRAM, 26'h01FFFFF, "R7 below window");
    drive(1, 26'h0200010, S_ROM1, 26'h0040010, "R8 lowest index");
    drive(1, 26'h0104321, S_DRAM, 26'h1FFC321, "R7 window over overlap");
    drive(1, 26'h0208000, S_DRAM, 26'h0208000, "R7 window end");
    drain();
    // R9 software remap
    wr(0, 32'h0000_0108);
    drive(1, 26'h0204567, S_CARD, 26'h0044567, "R9 sw remap");
    drive(1, 26'h0104321, S_DRAM, 26'h1FFC321, "R9 dram window kept");
    drain();
    // R9 strap remap, R10 width
    doReset(2'b10, 1'b1);
    checkWidth(2'b10, "R10 strap 32");
    wr(4, 32'h8300_1080);
    wr(5, 32'h0000_0020);
    drive(1, 26'h0200ABC, S_CARD, 26'h0080ABC, "R9 strap remap");
    drive(1, 26'h0FF0010, S_ROM0, 26'h0FF0010, "R9 rom0 unaffected");
    drain();
    @(negedge clk);
    romWidthStrap = 2'b00;
    repeat (2) @(negedge clk);
    checkWidth(2'b10, "R10 strap ignored");
    doReset(2'b00, 1'b0);
    checkWidth(2'b00, "R10 strap 8");
    wr(4, 32'h8300_1080);
    drive(1, 26'h0200ABC, S_ROM2, 26'h0000ABC, "R9 no remap rom2");
    drain();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule